// File: doc/BRIEF.md
# Integer ALU with Shifter and Compare

This block is the purely combinational execute stage of a small load-store RISC datapath. Each cycle it takes two 32-bit operands, a 5-bit shift count and a 4-bit operation code, and drives a 32-bit result together with a zero flag. It supports wrapping add and subtract, bitwise AND, OR and NOR, signed and unsigned set-less-than that return a 0/1 word, and three barrel shifts: logical left, logical right and arithmetic right. The shift count is a separate input and does not depend on either operand.

A front stage prepares the second operand. When `use_imm_i` is set, the 16-bit constant `imm_i` takes the place of `b_i`. It is widened by sign extension for arithmetic and compare immediates, or by zero extension for logical immediates, as `imm_sext_i` selects. The zero flag lets branch-equal logic test a subtraction directly. The block has no registers and no handshake. Its outputs follow its inputs within the same cycle, so back-pressure never applies.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) returns A + B modulo 2^32 with no exception; 0xFFFFFFFF + 1 gives 0.
- R2: Operation code 1 (subtract) returns A - B modulo 2^32; 0 - 1 gives 0xFFFFFFFF.
- R3: Operation code 2 returns the bitwise AND of A and B, and operation code 3 returns the bitwise OR.
- R4: Operation code 4 returns ~(A | B); with B equal to zero this is the bitwise NOT of A.
- R5: Operation code 5 returns 32'd1 when A < B as two's-complement numbers and 32'd0 otherwise; A = 0xFFFFFFFF, B = 1 gives 1.
- R6: Operation code 6 returns 32'd1 when A < B as unsigned numbers and 32'd0 otherwise; A = 0xFFFFFFFF, B = 1 gives 0.
- R7: Operation code 7 shifts A left by `shamt_i` (0 to 31) and fills with zeros; B has no effect.
- R8: Operation code 8 shifts A right by `shamt_i` and fills with zeros; B has no effect.
- R9: Operation code 9 shifts A right by `shamt_i` and fills with copies of A[31].
- R10: `zero_o` is 1 exactly when the 32-bit result is zero; subtracting equal operands sets it.
- R11: With `use_imm_i` = 1, B is `imm_i` sign-extended when `imm_sext_i` = 1 and zero-extended when it is 0, and `b_i` is ignored. Sign extension covers -32768 to 32767.
- R12: Operation codes 10 to 15 return 0, with `zero_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; the value that is shifted |
| b_i | input | 32 | Second operand from the register path |
| imm_i | input | 16 | Immediate constant |
| use_imm_i | input | 1 | Replace B with the widened immediate |
| imm_sext_i | input | 1 | 1: sign-extend the immediate, 0: zero-extend it |
| shamt_i | input | 5 | Shift count |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
The bound checker tests on every input change the properties that hold for any operand values. These are that an add can be undone by subtracting B, that NOR shares no set bit with A or B, that both compares yield only 0 or 1, that an arithmetic right shift keeps the sign, that a zero shift count passes A through, and that subtracting equal operands raises the zero flag. Only the directed scenarios show exact values. These include the carry wrap points, the opposite answers of the signed and unsigned compares on the same operands, the fill pattern at the largest shift counts, the difference between the two immediate extensions at the 0x8000 boundary, and the zero result of unused codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic pad_bit;
  assign pad_bit = sext_i & imm_i[IMM_W-1];
  assign ext_o   = {{PAD_W{pad_bit}}, imm_i};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_signed_o,
  output logic              lt_unsigned_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = wide[DATA_W-1:0];

  // Valid when sub_i is set: no carry out means a borrow, so A < B unsigned.
  assign lt_unsigned_o = ~wide[DATA_W];
  // Differing signs decide directly; equal signs cannot overflow.
  assign lt_signed_o   = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : wide[MSB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~or_o;
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  data_o
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic              fill;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar k = 0; k < DATA_W; k++) begin : g_rev
    assign rev_in[k]  = data_i[DATA_W-1-k];
    assign rev_out[k] = stage[SHAMT_W][DATA_W-1-k];
  end

  assign fill     = arith_i & ~left_i & data_i[DATA_W-1];
  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = shamt_i[i]
                      ? {{STEP{fill}}, stage[i][DATA_W-1:STEP]}
                      : stage[i];
  end

  assign data_o = left_i ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               use_imm_i,
  input  logic               imm_sext_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] and_r;
  logic [DATA_W-1:0] or_r;
  logic [DATA_W-1:0] nor_r;
  logic [DATA_W-1:0] shift_r;
  logic              do_sub;
  logic              shl;
  logic              sha;

  assign op = alu_op_e'(op_i);

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm_i  (imm_i),
    .sext_i (imm_sext_i),
    .ext_o  (imm_ext)
  );

  assign opnd_b = use_imm_i ? imm_ext : b_i;
  assign do_sub = (op != OP_ADD);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i           (a_i),
    .b_i           (opnd_b),
    .sub_i         (do_sub),
    .sum_o         (sum),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .and_o (and_r),
    .or_o  (or_r),
    .nor_o (nor_r)
  );

  assign shl = (op == OP_SLL);
  assign sha = (op == OP_SRA);

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .data_i  (a_i),
    .shamt_i (shamt_i),
    .left_i  (shl),
    .arith_i (sha),
    .data_o  (shift_r)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         result_o = sum;
      OP_AND:                 result_o = and_r;
      OP_OR:                  result_o = or_r;
      OP_NOR:                 result_o = nor_r;
      OP_SLT:                 result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA: result_o = shift_r;
      default:                result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic               use_imm_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [OP_W-1:0]    op_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               zero_o
);
  always_comb begin
    if (!use_imm_i) begin
      // R1
      add_inverse_chk: assert (op_i != OP_ADD || (result_o - b_i) == a_i);
      // R4
      nor_disjoint_chk: assert (op_i != OP_NOR || (result_o & (a_i | b_i)) == '0);
      // R10
      eq_zero_chk: assert (!(op_i == OP_SUB && a_i == b_i) || zero_o);
    end
    // R5
    slt_bool_chk: assert (!(op_i == OP_SLT || op_i == OP_SLTU) || result_o[DATA_W-1:1] == '0);
    // R9
    sra_sign_chk: assert (op_i != OP_SRA || result_o[DATA_W-1] == a_i[DATA_W-1]);
    // R7
    shift_zero_chk: assert (!((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && shamt_i == '0)
                            || result_o == a_i);
  end
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .use_imm_i (use_imm_i),
  .shamt_i   (shamt_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .zero_o    (zero_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        use_imm, imm_sext;
  logic [4:0]  shamt;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core u_alu_core (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .imm_sext_i(imm_sext),
    .shamt_i(shamt), .op_i(op), .result_o(result), .zero_o(zero)
  );

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_z);
    n_checks++;
    if (result !== exp_r || zero !== exp_z) begin
      n_fail++;
      $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b", req, result, zero, exp_r, exp_z);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [4:0] sh);
    @(negedge clk);
    op = o; a = av; b = bv; shamt = sh; use_imm = 1'b0; imm_sext = 1'b0; imm = '0;
    #1;
  endtask

  task automatic t_reset;
    // R12: idle inputs with an unused code give a zero result
    apply(4'd15, '0, '0, '0);
    check("R12 idle", 32'd0, 1'b1);
  endtask

  task automatic t_addsub;
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd7);
    check("R1 wrap", 32'd0, 1'b1);
    apply(4'd0, 32'h1234_5678, 32'h1111_1111, 5'd0);
    check("R1 add", 32'h2345_6789, 1'b0);
    apply(4'd1, 32'd0, 32'd1, 5'd0);
    check("R2 wrap", 32'hFFFF_FFFF, 1'b0);
    apply(4'd1, 32'h8000_0000, 32'h8000_0000, 5'd0);
    check("R10 equal", 32'd0, 1'b1);
  endtask

  task automatic t_logic;
    apply(4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
    check("R3 and", 32'h0000_0C00, 1'b0);
    apply(4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
    check("R3 or", 32'h0000_3DC0, 1'b0);
    apply(4'd4, 32'h0000_3C00, 32'd0, 5'd0);
    check("R4 not", 32'hFFFF_C3FF, 1'b0);
    apply(4'd4, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0);
    check("R4 all ones", 32'd0, 1'b1);
  endtask

  task automatic t_compare;
    apply(4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0);
    check("R5 neg<pos", 32'd1, 1'b0);
    apply(4'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
    check("R6 big>1", 32'd0, 1'b1);
    apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    check("R5 max>min", 32'd0, 1'b1);
    apply(4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    check("R6 lt", 32'd1, 1'b0);
    apply(4'd5, 32'd5, 32'd5, 5'd0);
    check("R5 equal", 32'd0, 1'b1);
  endtask

  task automatic t_shift;
    for (int s = 0; s < 32; s += 31) begin
      apply(4'd7, 32'h8000_0001, 32'hDEAD_BEEF, 5'(s));
      check("R7 sll", 32'h8000_0001 << s, (32'h8000_0001 << s) == 0);
      apply(4'd8, 32'h8000_0001, 32'hDEAD_BEEF, 5'(s));
      check("R8 srl", 32'h8000_0001 >> s, (32'h8000_0001 >> s) == 0);
      apply(4'd9, 32'h8000_0001, 32'hDEAD_BEEF, 5'(s));
      check("R9 sra", 32'($signed(32'h8000_0001) >>> s), 1'b0);
    end
    apply(4'd7, 32'h00FF_0000, 32'd0, 5'd8);
    check("R7 mid", 32'hFF00_0000, 1'b0);
    apply(4'd8, 32'hFF00_0000, 32'hFFFF_FFFF, 5'd24);
    check("R8 mid", 32'h0000_00FF, 1'b0);
    apply(4'd9, 32'h7000_0000, 32'd0, 5'd4);
    check("R9 positive", 32'h0700_0000, 1'b0);
    apply(4'd9, 32'hF000_0000, 32'd0, 5'd8);
    check("R9 negative", 32'hFFF0_0000, 1'b0);
  endtask

  task automatic t_imm;
    @(negedge clk);
    op = 4'd0; a = 32'd100; b = 32'h5555_5555; use_imm = 1'b1; imm_sext = 1'b1; imm = 16'h8000; #1;
    check("R11 sext", 32'd100 - 32'd32768, 1'b0);
    imm_sext = 1'b0; #1;
    check("R11 zext", 32'd100 + 32'd32768, 1'b0);
    op = 4'd3; a = 32'h1234_0000; imm = 16'hFF00; imm_sext = 1'b0; #1;
    check("R11 ori", 32'h1234_FF00, 1'b0);
    op = 4'd5; a = 32'hFFFF_FFF0; imm = 16'hFFFF; imm_sext = 1'b1; #1;
    check("R11 slti", 32'd1, 1'b0);
    op = 4'd1; a = 32'h0000_7FFF; imm = 16'h7FFF; #1;
    check("R11 max", 32'd0, 1'b1);
  endtask

  task automatic t_unused;
    for (int c = 10; c < 16; c++) begin
      apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3);
      check("R12 code", 32'd0, 1'b1);
    end
  endtask

  initial begin
    a = '0; b = '0; imm = '0; use_imm = 1'b0; imm_sext = 1'b0; shamt = '0; op = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addsub();
    t_logic();
    t_compare();
    t_shift();
    t_imm();
    t_unused();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: expected=completion actual=timeout");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule